// File: doc/BRIEF.md
# Segmented Indexed-Element Lane Router

This block prepares the operand lanes for a widening, by-element vector operation. It takes two vectors of 16-bit elements. For every 32-bit result lane it outputs one half-width element from the first vector and one broadcast element from the second vector, so that a downstream widening multiply-accumulate unit receives ready-aligned operand pairs. The arithmetic and the register storage sit outside this block.

The first-vector element for lane e is taken from position 2e+1 when the odd-pass select is high, and from position 2e when it is low. A full operation therefore uses two passes, one over the even elements and one over the odd elements. The second-vector element is chosen by a 3-bit index inside each 128-bit segment. The index is the same for every segment, but each segment broadcasts its own element to its four lanes, so the result is not one global scalar.

The vector width `VL` is a parameter. It must be a positive multiple of 128 bits, and elaboration stops with an error when it is not. The parameter `OUT_REG` either adds a one-cycle output register with an asynchronous active-low reset (value 1, the default) or leaves the path purely combinational (value 0).

Top module: `seg_lane_router`

## Requirements
- R1: With `odd_sel`=0, lane e of `lane_a` (bits 16e+15..16e, lane 0 least significant) equals element 2e of `vec_a`. Element k of a vector occupies bits 16k+15..16k.
- R2: With `odd_sel`=1, lane e of `lane_a` equals element 2e+1 of `vec_a`.
- R3: Lane e of `lane_b` equals element 8*floor(e/4)+`elem_idx` of `vec_b`. This is position 2*(e-(e mod 4))+`elem_idx`.
- R4: All four lanes of a 128-bit segment in `lane_b` carry the same value, taken from that segment of `vec_b` alone. Elements of `vec_b` at non-indexed positions have no effect on `lane_b`.
- R5: Every index value 0 through 7 selects its own element, including the boundary values 0 and 7.
- R6: With `OUT_REG`=1, the outputs update at the rising clock edge after the inputs are presented and hold their value between edges.
- R7: With `OUT_REG`=1, a low `rst_n` clears `lane_a` and `lane_b` to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_a | input | VL | First source, VL/16 elements of 16 bits |
| vec_b | input | VL | Second source, VL/16 elements of 16 bits |
| elem_idx | input | 3 | Element index inside each 128-bit segment |
| odd_sel | input | 1 | Pass select: 0 picks even elements, 1 picks odd elements |
| lane_a | output | VL/2 | VL/32 lanes of 16 bits from `vec_a` |
| lane_b | output | VL/2 | VL/32 lanes of 16 bits broadcast from `vec_b` |

## Verification
The hardest property to show from the ports is that each segment broadcasts its own element and that non-indexed elements of the second vector are truly ignored. A plain sweep would pass even if every segment copied segment 0. The stimulus therefore loads second vectors whose elements differ in every segment. It then flips every non-indexed element while the index stays fixed and confirms that `lane_b` is unchanged. Finally it changes only the indexed element of one middle segment and confirms that only that segment's four lanes move.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
    localparam int ELEM_W        = 16;
    localparam int LANE_W        = 32;
    localparam int SEG_W         = 128;
    localparam int IDX_W         = 3;
    localparam int LANES_PER_SEG = SEG_W / LANE_W;
    localparam int ELEMS_PER_SEG = SEG_W / ELEM_W;

    typedef logic [ELEM_W-1:0] elem_t;
endpackage

// File: rtl/lrt_pair_pick.sv
module lrt_pair_pick
    import lrt_pkg::*;
#(
    parameter int LANES = 16,
    localparam int IN_W  = 2 * LANES * ELEM_W,
    localparam int OUT_W = LANES * ELEM_W
) (
    input  logic [IN_W-1:0]  src,
    input  logic             odd_sel,
    output logic [OUT_W-1:0] picked
);
    for (genvar e = 0; e < LANES; e++) begin : g_lane
        elem_t even_el;
        elem_t odd_el;
        assign even_el = src[(2*e)*ELEM_W +: ELEM_W];
        assign odd_el  = src[(2*e+1)*ELEM_W +: ELEM_W];
        assign picked[e*ELEM_W +: ELEM_W] = odd_sel ? odd_el : even_el;
    end
endmodule

// File: rtl/lrt_seg_bcast.sv
module lrt_seg_bcast
    import lrt_pkg::*;
#(
    parameter int SEGS = 4,
    localparam int IN_W  = SEGS * SEG_W,
    localparam int OUT_W = SEGS * LANES_PER_SEG * ELEM_W
) (
    input  logic [IN_W-1:0]  src,
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] bcast
);
    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        logic [SEG_W-1:0] seg_slice;
        elem_t            pick;

        assign seg_slice = src[s*SEG_W +: SEG_W];

        always_comb begin
            pick = '0;
            for (int k = 0; k < ELEMS_PER_SEG; k++) begin
                if (idx == k[IDX_W-1:0]) begin
                    pick = seg_slice[k*ELEM_W +: ELEM_W];
                end
            end
        end

        for (genvar l = 0; l < LANES_PER_SEG; l++) begin : g_rep
            assign bcast[(s*LANES_PER_SEG + l)*ELEM_W +: ELEM_W] = pick;
        end
    end
endmodule

// File: rtl/lrt_out_stage.sv
module lrt_out_stage #(
    parameter int W       = 256,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/seg_lane_router.sv
module seg_lane_router
    import lrt_pkg::*;
#(
    parameter int VL      = 512,
    parameter bit OUT_REG = 1'b1,
    localparam int LANES  = VL / LANE_W,
    localparam int SEGS   = VL / SEG_W,
    localparam int OUT_W  = LANES * ELEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VL-1:0]    vec_a,
    input  logic [VL-1:0]    vec_b,
    input  logic [IDX_W-1:0] elem_idx,
    input  logic             odd_sel,
    output logic [OUT_W-1:0] lane_a,
    output logic [OUT_W-1:0] lane_b
);
    if ((VL % SEG_W) != 0 || VL < SEG_W) begin : g_bad_vl
        $error("seg_lane_router: VL must be a positive multiple of 128");
    end

    logic [OUT_W-1:0] pick_a;
    logic [OUT_W-1:0] pick_b;

    lrt_pair_pick #(.LANES(LANES)) u_pair (
        .src     (vec_a),
        .odd_sel (odd_sel),
        .picked  (pick_a)
    );

    lrt_seg_bcast #(.SEGS(SEGS)) u_bcast (
        .src   (vec_b),
        .idx   (elem_idx),
        .bcast (pick_b)
    );

    lrt_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_out_a (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pick_a),
        .q     (lane_a)
    );

    lrt_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_out_b (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pick_b),
        .q     (lane_b)
    );
endmodule

// File: rtl/lrt_router_chk.sv
module lrt_router_chk
    import lrt_pkg::*;
#(
    parameter int VL      = 512,
    parameter bit OUT_REG = 1'b1,
    localparam int LANES  = VL / LANE_W,
    localparam int SEGS   = VL / SEG_W,
    localparam int OUT_W  = LANES * ELEM_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VL-1:0]    vec_a,
    input logic [VL-1:0]    vec_b,
    input logic [IDX_W-1:0] elem_idx,
    input logic             odd_sel,
    input logic [OUT_W-1:0] lane_a,
    input logic [OUT_W-1:0] lane_b
);
    logic [OUT_W-1:0] model_a;
    logic [OUT_W-1:0] model_b;

    // Reference selection written from the element-position formulas.
    always_comb begin
        for (int e = 0; e < LANES; e++) begin
            model_a[e*ELEM_W +: ELEM_W] = vec_a[(2*e + int'(odd_sel))*ELEM_W +: ELEM_W];
            model_b[e*ELEM_W +: ELEM_W] =
                vec_b[(2*(e - (e % LANES_PER_SEG)) + int'(elem_idx))*ELEM_W +: ELEM_W];
        end
    end

    if (OUT_REG) begin : g_reg_chk
        p_even_pick_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !odd_sel |=> lane_a == $past(model_a));

        p_odd_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
            odd_sel |=> lane_a == $past(model_a));

        p_seg_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> lane_b == $past(model_b));

        always @(negedge clk) begin
            if (!rst_n) begin
                p_reset_clear_r7: assert (lane_a == '0 && lane_b == '0);
            end
        end
    end else begin : g_comb_chk
        always @(negedge clk) begin
            p_even_pick_r1: assert (odd_sel || lane_a == model_a);
            p_odd_pick_r2: assert (!odd_sel || lane_a == model_a);
            p_seg_pick_r3: assert (lane_b == model_b);
        end
    end

    for (genvar s = 0; s < SEGS; s++) begin : g_uni
        p_seg_uniform_r4: assert property (@(posedge clk) disable iff (!rst_n)
            lane_b[(s*4)*ELEM_W +: ELEM_W] == lane_b[(s*4+1)*ELEM_W +: ELEM_W] &&
            lane_b[(s*4)*ELEM_W +: ELEM_W] == lane_b[(s*4+2)*ELEM_W +: ELEM_W] &&
            lane_b[(s*4)*ELEM_W +: ELEM_W] == lane_b[(s*4+3)*ELEM_W +: ELEM_W]);
    end
endmodule

bind seg_lane_router lrt_router_chk #(.VL(VL), .OUT_REG(OUT_REG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_a    (vec_a),
    .vec_b    (vec_b),
    .elem_idx (elem_idx),
    .odd_sel  (odd_sel),
    .lane_a   (lane_a),
    .lane_b   (lane_b)
);

// File: tb/seg_lane_router_test.sv
module seg_lane_router_test;
    localparam int VL    = 512;
    localparam int LANES = VL / 32;
    localparam int OW    = LANES * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VL-1:0] vec_a = '0;
    logic [VL-1:0] vec_b = '0;
    logic [2:0]    elem_idx = '0;
    logic          odd_sel = 1'b0;
    logic [OW-1:0] lane_a;
    logic [OW-1:0] lane_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    seg_lane_router #(.VL(VL), .OUT_REG(1'b1)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .vec_a    (vec_a),
        .vec_b    (vec_b),
        .elem_idx (elem_idx),
        .odd_sel  (odd_sel),
        .lane_a   (lane_a),
        .lane_b   (lane_b)
    );

    function automatic logic [VL-1:0] pat(input int seed);
        logic [VL-1:0] r;
        for (int k = 0; k < VL/16; k++) begin
            r[k*16 +: 16] = 16'(seed * 16'h3B1 + k * 16'h0107 + k * k * 5 + 1);
        end
        return r;
    endfunction

    function automatic logic [OW-1:0] exp_a(input logic [VL-1:0] s, input bit odd);
        logic [OW-1:0] r;
        for (int e = 0; e < LANES; e++) begin
            r[e*16 +: 16] = s[(2*e + int'(odd))*16 +: 16];
        end
        return r;
    endfunction

    function automatic logic [OW-1:0] exp_b(input logic [VL-1:0] s, input int ix);
        logic [OW-1:0] r;
        for (int e = 0; e < LANES; e++) begin
            r[e*16 +: 16] = s[(8*(e/4) + ix)*16 +: 16];
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present inputs at a falling edge, sample after the next rising edge.
    task automatic apply(input logic [VL-1:0] a, input logic [VL-1:0] b,
                         input int ix, input bit odd);
        @(negedge clk);
        vec_a = a; vec_b = b; elem_idx = 3'(ix); odd_sel = odd;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        #1;
        chk("R7", "lane_a in reset", lane_a, '0);
        chk("R7", "lane_b in reset", lane_b, '0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_even_pass;
        for (int s = 1; s <= 3; s++) begin
            apply(pat(s), pat(s + 40), 2, 1'b0);
            chk("R1", "even elements", lane_a, exp_a(pat(s), 1'b0));
        end
    endtask

    task automatic t_odd_pass;
        for (int s = 4; s <= 6; s++) begin
            apply(pat(s), pat(s + 40), 5, 1'b1);
            chk("R2", "odd elements", lane_a, exp_a(pat(s), 1'b1));
        end
    endtask

    task automatic t_idx_sweep;
        for (int ix = 0; ix < 8; ix++) begin
            apply(pat(ix + 10), pat(ix + 20), ix, ix[0]);
            chk("R3", "segment broadcast", lane_b, exp_b(pat(ix + 20), ix));
            if (ix == 0 || ix == 7) begin
                chk("R5", "boundary index", lane_b, exp_b(pat(ix + 20), ix));
            end
        end
    endtask

    task automatic t_seg_independence;
        logic [VL-1:0] b;
        logic [OW-1:0] ref_b;
        logic [OW-1:0] want;
        b = pat(77);
        apply(pat(1), b, 3, 1'b0);
        ref_b = lane_b;
        chk("R4", "base broadcast", ref_b, exp_b(b, 3));
        // flip every element that is not at position 3 of its segment
        for (int k = 0; k < VL/16; k++) begin
            if ((k % 8) != 3) b[k*16 +: 16] = ~b[k*16 +: 16];
        end
        apply(pat(1), b, 3, 1'b0);
        chk("R4", "non-indexed elements ignored", lane_b, ref_b);
        // change only the indexed element of segment 2 (element 19)
        b[19*16 +: 16] = 16'hBEEF;
        want = ref_b;
        for (int l = 8; l < 12; l++) want[l*16 +: 16] = 16'hBEEF;
        apply(pat(1), b, 3, 1'b0);
        chk("R4", "only segment 2 moves", lane_b, want);
    endtask

    task automatic t_latency;
        logic [OW-1:0] old_a;
        apply(pat(50), pat(51), 1, 1'b0);
        old_a = lane_a;
        @(negedge clk);
        vec_a = pat(52); odd_sel = 1'b1;
        #1;
        chk("R6", "hold before edge", lane_a, old_a);
        @(negedge clk);
        chk("R6", "update after edge", lane_a, exp_a(pat(52), 1'b1));
    endtask

    task automatic t_reset_mid;
        apply(pat(60), pat(61), 6, 1'b1);
        chk("R7", "data before reset", lane_b, exp_b(pat(61), 6));
        #1;
        rst_n = 1'b0;
        #1;
        chk("R7", "async clear lane_a", lane_a, '0);
        chk("R7", "async clear lane_b", lane_b, '0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(pat(62), pat(63), 4, 1'b0);
        chk("R1", "after reset release", lane_a, exp_a(pat(62), 1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_even_pass();
        t_odd_pass();
        t_idx_sweep();
        t_seg_independence();
        t_latency();
        t_reset_mid();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule